// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator Counter

This block is an 8-bit accumulator for a microcontroller timer subsystem. A single counter serves two purposes, picked by a mode bit. In event mode it counts transitions on an asynchronous external input. In gated mode it counts ticks of a free-running divide-by-64 prescaler, but only while that external input sits at its active level. A polarity bit picks the counted edge or the active gate level.

All logic runs on one system clock. An E-clock enable marks the E cycles that the synchronizer, edge detector, prescaler and counter advance on. Software can load the count at any time through a write strobe, and a sticky wrap flag records every roll-over from the top count to zero. Software clears the flag by writing 1 to its clear input.

Top module: `pacc_top`

## Requirements
- R1: After reset the count output is 0x00 and the overflow flag is 0.
- R2: With mode input 0 (event mode) and enable 1, the count rises by exactly one per qualifying pin edge: polarity 1 counts low-to-high edges and polarity 0 counts high-to-low edges. The count never changes by more than one step without a write.
- R3: In event mode, pin pulses whose high and low phases each last one E cycle (pin rate of E/2) are all counted.
- R4: With mode input 1 (gated mode) and enable 1, the count rises by one on each prescaler tick (one tick per PRESCALE E cycles) while the synchronized pin is active: high when polarity is 0, low when polarity is 1. A gate-active window of k*PRESCALE E cycles adds exactly k.
- R5: In gated mode, while the pin is inactive, the count does not change.
- R6: A write strobe loads the write data into the count on the next clock edge in either mode, whether or not the block is enabled.
- R7: An increment from 0xFF gives 0x00 and sets the overflow flag.
- R8: The overflow flag stays set through further counting until the clear input is 1 for a cycle; a set in the same cycle takes priority over the clear.
- R9: When a write and an increment fall on the same clock edge, the written value is kept and the increment is lost.
- R10: With enable 0, pin activity in either mode leaves the count unchanged.
- R11: The pin is sampled only in cycles with the E enable high; while the E enable stays low, pin activity has no effect. A level held across that time is seen once the enable resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e_en | input | 1 | E-clock enable, one system cycle per E cycle |
| pin_async | input | 1 | Asynchronous external pulse or gate input |
| ctl_enable | input | 1 | 1 lets the counter advance |
| ctl_mode | input | 1 | 0 event counting, 1 gated time accumulation |
| ctl_polarity | input | 1 | Event: 1 rising, 0 falling; gated: 0 active-high, 1 active-low |
| cnt_wr | input | 1 | Write strobe for the count |
| cnt_wdata | input | 8 | Value loaded by a write |
| ovf_clr | input | 1 | Write 1 to clear the overflow flag |
| cnt_value | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
The bench builds the block with a prescale ratio of 8 in place of 64, so that multi-tick gate windows and a full gated wrap fit in a short run. With that ratio, a window of any multiple of eight E cycles must add an exact count whatever the prescaler phase. This lets gated-mode results be predicted without modelling the prescaler's phase. The counter width and synchronizer depth stay at their defaults, so the 0xFF roll-over and the three-cycle pin-to-count latency are those of the shipped configuration.

// File: rtl/pacc_pkg.sv
// Shared types for the pulse accumulator.
// Assumes: mode is a single control bit, 0 selects event counting.
package pacc_pkg;
    typedef enum logic {
        MODE_EVENT = 1'b0,
        MODE_GATED = 1'b1
    } acc_mode_e;
endpackage

// File: rtl/pacc_pin_sync.sv
// Pin synchronizer and edge detector.
// Shifts the asynchronous pin through STAGES flops on E-enable cycles and
// keeps one more flop of history for edge detection. Assumes STAGES >= 2.
module pacc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e_en,
    input  logic pin_async,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Purpose: sample the pin into the synchronizer chain once per E cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else if (e_en) begin
            chain <= {chain[STAGES-2:0], pin_async};
            prev  <= chain[STAGES-1];
        end
    end

    // Purpose: present the synchronized level and its transitions.
    always_comb begin
        level = chain[STAGES-1];
        rise  = chain[STAGES-1] & ~prev;
        fall  = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/pacc_prescaler.sv
// Free-running E-cycle divider. Gives a one-cycle tick every PRESCALE
// E-enable cycles. Only reset restarts it; the gate never touches it.
module pacc_prescaler #(
    parameter int PRESCALE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e_en,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_bypass
            // Purpose: with no division every E cycle is a tick.
            always_comb tick = e_en;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] div_q;

            // Purpose: advance the divider once per E cycle and wrap at LAST.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (e_en) begin
                    div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
                end
            end

            // Purpose: flag the E cycle on which the divider wraps.
            always_comb tick = e_en && (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/pacc_qualify.sv
// Increment qualifier. Chooses the edge or the gated tick that advances the
// counter, from the mode and polarity bits. Assumes rise/fall/level come
// from flops that update only on E-enable cycles.
module pacc_qualify
    import pacc_pkg::*;
(
    input  logic      e_en,
    input  logic      enable,
    input  acc_mode_e mode,
    input  logic      polarity,
    input  logic      rise,
    input  logic      fall,
    input  logic      level,
    input  logic      tick,
    output logic      inc
);
    logic edge_hit;
    logic gate_open;

    // Purpose: pick the edge type and the gate sense from polarity.
    always_comb begin
        edge_hit  = e_en && (polarity ? rise : fall);
        gate_open = polarity ? ~level : level;
    end

    // Purpose: form the single increment request for this cycle.
    always_comb begin
        inc = 1'b0;
        if (enable) begin
            unique case (mode)
                MODE_EVENT: inc = edge_hit;
                MODE_GATED: inc = tick && gate_open;
                default:    inc = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pacc_count_core.sv
// Count register with sticky wrap flag. A software load wins over an
// increment in the same cycle. Setting the flag wins over clearing it.
module pacc_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic do_inc;
    logic wrap;

    // Purpose: drop an increment that collides with a software load.
    always_comb begin
        do_inc = inc && !wr;
        wrap   = do_inc && (count == TOP);
    end

    // Purpose: update the count from a load or an increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr) begin
            count <= wdata;
        end else if (do_inc) begin
            count <= count + 1'b1;
        end
    end

    // Purpose: hold the wrap flag until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (wrap) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/pacc_top.sv
// Dual-mode pulse accumulator top. Wires synchronizer, prescaler,
// qualifier and count core. Assumes e_en is a one-cycle-per-E enable and
// that control inputs are register outputs in the clk domain.
module pacc_top
    import pacc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRESCALE    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             e_en,
    input  logic             pin_async,
    input  logic             ctl_enable,
    input  logic             ctl_mode,
    input  logic             ctl_polarity,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_value,
    output logic             ovf_flag
);
    logic      pin_level;
    logic      pin_rise;
    logic      pin_fall;
    logic      presc_tick;
    logic      inc_req;
    acc_mode_e mode_sel;

    // Purpose: map the raw mode bit onto the mode type.
    always_comb mode_sel = acc_mode_e'(ctl_mode);

    pacc_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .e_en      (e_en),
        .pin_async (pin_async),
        .level     (pin_level),
        .rise      (pin_rise),
        .fall      (pin_fall)
    );

    pacc_prescaler #(.PRESCALE(PRESCALE)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .e_en  (e_en),
        .tick  (presc_tick)
    );

    pacc_qualify qual_i (
        .e_en     (e_en),
        .enable   (ctl_enable),
        .mode     (mode_sel),
        .polarity (ctl_polarity),
        .rise     (pin_rise),
        .fall     (pin_fall),
        .level    (pin_level),
        .tick     (presc_tick),
        .inc      (inc_req)
    );

    pacc_count_core #(.CNT_W(CNT_W)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc_req),
        .wr      (cnt_wr),
        .wdata   (cnt_wdata),
        .ovf_clr (ovf_clr),
        .count   (cnt_value),
        .ovf     (ovf_flag)
    );
endmodule

// File: rtl/pacc_checker.sv
// Property checker for pacc_top, attached by bind below.
module pacc_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             e_en,
    input logic             ctl_enable,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] cnt_value,
    input logic             ovf_flag,
    input logic             tick
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R1: reset state
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (cnt_value == '0 && !ovf_flag));

    // R2: never more than one step without a write
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt_value == $past(cnt_value)) ||
                    (cnt_value == CNT_W'($past(cnt_value) + 1'b1)));

    // R4: prescaler tick only on an E cycle
    a_r4_tick_on_e: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> e_en);

    // R6: a write loads its data
    a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_value == $past(cnt_wdata));

    // R7: flag rises only on a wrap to zero
    a_r7_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt_value) == TOP && cnt_value == '0));

    // R8: flag is sticky until cleared
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R10: disabled counter holds
    a_r10_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_enable && !cnt_wr) |=> $stable(cnt_value));

    // R11: nothing advances without the E enable
    a_r11_no_e_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_en && !cnt_wr) |=> $stable(cnt_value));
endmodule

bind pacc_top pacc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .e_en       (e_en),
    .ctl_enable (ctl_enable),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .ovf_clr    (ovf_clr),
    .cnt_value  (cnt_value),
    .ovf_flag   (ovf_flag),
    .tick       (presc_tick)
);

// File: tb/pacc_top_tb_top.sv
// Scoreboard bench for pacc_top: driver tasks queue expected results,
// a monitor pops them at falling edges and compares with the outputs.
module pacc_top_tb_top;
    localparam int CNT_W    = 8;
    localparam int PRESCALE = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             e_en = 1'b1;
    logic             pin_async = 1'b0;
    logic             ctl_enable = 1'b0;
    logic             ctl_mode = 1'b0;
    logic             ctl_polarity = 1'b1;
    logic             cnt_wr = 1'b0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic             ovf_clr = 1'b0;
    logic [CNT_W-1:0] cnt_value;
    logic             ovf_flag;

    typedef struct {
        string            tag;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    pacc_top #(.CNT_W(CNT_W), .PRESCALE(PRESCALE), .SYNC_STAGES(2)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .e_en         (e_en),
        .pin_async    (pin_async),
        .ctl_enable   (ctl_enable),
        .ctl_mode     (ctl_mode),
        .ctl_polarity (ctl_polarity),
        .cnt_wr       (cnt_wr),
        .cnt_wdata    (cnt_wdata),
        .ovf_clr      (ovf_clr),
        .cnt_value    (cnt_value),
        .ovf_flag     (ovf_flag)
    );

    // Monitor: compare queued expectations away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (cnt_value !== e.cnt || ovf_flag !== e.ovf) begin
                    n_fail++;
                    $display("FAIL %s: cnt=%h ovf=%b expected cnt=%h ovf=%b",
                             e.tag, cnt_value, ovf_flag, e.cnt, e.ovf);
                end
            end
        end
    end

    task automatic expect_state(input string tag, input logic [CNT_W-1:0] c,
                                input logic o);
        exp_t e;
        e.tag = tag; e.cnt = c; e.ovf = o;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            pin_async = 1'b1; idle(hi);
            pin_async = 1'b0; idle(lo);
        end
        idle(4);
    endtask

    task automatic load(input logic [CNT_W-1:0] v);
        cnt_wr = 1'b1; cnt_wdata = v; idle(1);
        cnt_wr = 1'b0; idle(1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Driver
    initial begin
        idle(3);
        expect_state("R1 reset", 8'h00, 1'b0);
        rst_n = 1'b1; idle(2);
        expect_state("R1 after release", 8'h00, 1'b0);

        ctl_enable = 1'b1; ctl_mode = 1'b0; ctl_polarity = 1'b1;
        pulses(3, 3, 3);
        expect_state("R2 rising edges", 8'h03, 1'b0);

        ctl_polarity = 1'b0; idle(2);
        pulses(2, 3, 3);
        expect_state("R2 falling edges", 8'h05, 1'b0);

        ctl_polarity = 1'b1;
        pulses(6, 1, 1);
        expect_state("R3 E/2 rate", 8'h0B, 1'b0);

        // Gated mode, active-high gate
        ctl_mode = 1'b1; ctl_polarity = 1'b0; idle(4);
        expect_state("R5 gate closed hold", 8'h0B, 1'b0);
        idle(40);
        expect_state("R5 gate closed long", 8'h0B, 1'b0);
        load(8'h5A);
        expect_state("R6 write in gated", 8'h5A, 1'b0);
        pin_async = 1'b1; idle(3 * PRESCALE);
        pin_async = 1'b0; idle(4);
        expect_state("R4 gated active high", 8'h5D, 1'b0);

        // Active-low gate: pin high is closed
        pin_async = 1'b1; ctl_polarity = 1'b1; idle(4);
        load(8'h10);
        idle(3 * PRESCALE);
        expect_state("R5 active-low gate closed", 8'h10, 1'b0);
        pin_async = 1'b0; idle(2 * PRESCALE);
        pin_async = 1'b1; idle(4);
        expect_state("R4 gated active low", 8'h12, 1'b0);
        pin_async = 1'b0;

        // Back to event mode, rising
        ctl_mode = 1'b0; ctl_polarity = 1'b1; idle(4);
        load(8'hFE);
        pulses(2, 2, 2);
        expect_state("R7 wrap sets flag", 8'h00, 1'b1);
        pulses(1, 2, 2);
        expect_state("R8 flag sticky", 8'h01, 1'b1);
        ovf_clr = 1'b1; idle(1); ovf_clr = 1'b0; idle(1);
        expect_state("R8 flag cleared", 8'h01, 1'b0);

        // Write collides with an increment
        pin_async = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 8'h40;
        @(negedge clk); cnt_wr = 1'b0;
        pin_async = 1'b0; idle(4);
        expect_state("R9 write beats increment", 8'h40, 1'b0);

        // Disabled
        ctl_enable = 1'b0;
        pulses(4, 2, 2);
        expect_state("R10 event frozen", 8'h40, 1'b0);
        ctl_mode = 1'b1; ctl_polarity = 1'b0;
        pin_async = 1'b1; idle(3 * PRESCALE); pin_async = 1'b0; idle(4);
        expect_state("R10 gated frozen", 8'h40, 1'b0);
        load(8'h22);
        expect_state("R6 write while disabled", 8'h22, 1'b0);

        // E enable held low
        ctl_mode = 1'b0; ctl_polarity = 1'b1; ctl_enable = 1'b1; idle(4);
        e_en = 1'b0;
        pulses(3, 2, 2);
        expect_state("R11 pulses ignored without E", 8'h22, 1'b0);
        pin_async = 1'b1; idle(6);
        expect_state("R11 held level waits", 8'h22, 1'b0);
        e_en = 1'b1; idle(5);
        expect_state("R11 seen after E resumes", 8'h23, 1'b0);
        pin_async = 1'b0; idle(4);

        idle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule